// File: doc/BRIEF.md
# Banked Auxiliary Control Register Access Controller

This block holds one 32-bit auxiliary control register, kept as three copies: a secure copy, a non-secure copy and a single unbanked copy. Requests arrive on a move-to / move-from coprocessor register port. Each request carries a five-field opcode tuple, the requesting exception level (0 to 3), a write flag and write data. A set of level inputs describes the rest of the processor: whether EL2 is enabled, the register width state of EL2 and EL3, whether EL3 exists, the non-secure state bit, and the four hypervisor trap bits.

The block first checks the tuple. It then applies privilege and the trap controls in a fixed priority order and resolves each request to one of five results. These are: not handled, undefined instruction, system-access trap to a 64-bit EL2, hypervisor trap to a 32-bit EL2, or granted. A granted request reads or writes the copy chosen by the exception level, the EL3 state and the non-secure bit.

The result is registered and appears one clock after the request together with a done pulse. A small two-state machine sequences this. ST_IDLE moves to ST_RESP when a request is presented (transition GO). ST_RESP stays in ST_RESP on a back-to-back request (transition AGAIN) and returns to ST_IDLE when there is none (transition REST). Done is high exactly in ST_RESP.

Top module: `banked_auxreg_ctrl`

## Requirements
- R1: A request is handled only when coprocessor=4'b1111, opc1=3'b000, CRn=4'b0001, CRm=4'b0000 and opc2=3'b011. Any other tuple gives done=1 with handled, undefined, both trap outputs, syndrome and read data all 0, and it changes no copy.
- R2: A matching request from EL0 returns undefined=1 and changes no copy.
- R3: At EL1 with EL2 enabled, the first set check in this order decides a trap:
  - the coarse trap bit for a 64-bit EL2;
  - the coarse trap bit for a 32-bit EL2;
  - the auxiliary trap bit for a 64-bit EL2;
  - the auxiliary trap bit for a 32-bit EL2.

  A trap bit that belongs to the EL2 state not in use is ignored. Trap bits are ignored when EL2 is disabled, and they are ignored at EL2 and EL3.
- R4: A trap with EL2 in 64-bit state raises the system-access trap output. A trap with EL2 in 32-bit state raises the hypervisor trap output. Both put syndrome class 6'h03 on the syndrome output. When no trap is raised, the syndrome output is 0.
- R5: A granted request at EL1 or EL2 uses the non-secure copy when EL3 exists and is in 32-bit state. Otherwise it uses the unbanked copy.
- R6: A granted request at EL3 uses the secure copy when the non-secure bit is 0 and the non-secure copy when it is 1.
- R7: After reset all three copies read 0 and every response output is 0.
- R8: An undefined or trapped write changes no copy. An undefined or trapped read, and every write, returns read data 0. A granted read returns the selected copy as it was before the response edge.
- R9: Done is high in the cycle after each clock with a request presented, and only then. Undefined and the two trap outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register (write), 0 = move from register (read) |
| req_cp | input | 4 | Coprocessor field of the tuple |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Second opcode field |
| req_el | input | 2 | Exception level of the requester |
| req_wdata | input | 32 | Write data |
| cfg_el2_en | input | 1 | EL2 enabled |
| cfg_el2_is32 | input | 1 | EL2 in 32-bit state |
| cfg_el3_present | input | 1 | EL3 implemented |
| cfg_el3_is32 | input | 1 | EL3 in 32-bit state |
| cfg_ns | input | 1 | Non-secure state bit |
| cfg_coarse_a64 | input | 1 | Coarse trap bit, 64-bit EL2 control |
| cfg_coarse_a32 | input | 1 | Coarse trap bit, 32-bit EL2 control |
| cfg_aux_a64 | input | 1 | Auxiliary trap bit, 64-bit EL2 control |
| cfg_aux_a32 | input | 1 | Auxiliary trap bit, 32-bit EL2 control |
| rsp_done | output | 1 | Response valid, one cycle after a request |
| rsp_handled | output | 1 | Tuple matched |
| rsp_undef | output | 1 | Undefined instruction result |
| rsp_trap_sys64 | output | 1 | System-access trap to 64-bit EL2 |
| rsp_trap_hyp32 | output | 1 | Hypervisor trap to 32-bit EL2 |
| rsp_syndrome | output | 6 | Syndrome class of a trap |
| rsp_rdata | output | 32 | Read data |

## Verification
A vector table writes distinct values into the three copies from EL3 with each setting of the non-secure bit and from EL2 with and without a 32-bit EL3. It then reads them back from EL1, EL2 and EL3. Distinct values show which copy each combination of level and state bits selects. Trap rows set each trap bit alone, all four together, and bits that belong to the EL2 state not in use or to a disabled EL2. These rows separate the two trap kinds and show that an unused bit is ignored. Trapped and undefined writes are followed by reads to confirm the copies did not change. Directed tests vary each tuple field alone, including from EL0, where a tuple miss must win over undefined. They also check the reset value of every copy and the one-cycle done pulse.

// File: rtl/auxreg_pkg.sv
package auxreg_pkg;

    localparam logic [3:0] TUPLE_CP  = 4'b1111;
    localparam logic [2:0] TUPLE_OP1 = 3'b000;
    localparam logic [3:0] TUPLE_CRN = 4'b0001;
    localparam logic [3:0] TUPLE_CRM = 4'b0000;
    localparam logic [2:0] TUPLE_OP2 = 3'b011;

    localparam int NUM_SLOTS = 3;
    localparam int SLOT_IW   = $clog2(NUM_SLOTS);

    typedef enum logic [SLOT_IW-1:0] {
        SLOT_SEC  = 2'd0,
        SLOT_NSEC = 2'd1,
        SLOT_UNB  = 2'd2
    } slot_e;

    typedef enum logic [2:0] {
        RES_MISS     = 3'd0,
        RES_UNDEF    = 3'd1,
        RES_TRAP_A64 = 3'd2,
        RES_TRAP_A32 = 3'd3,
        RES_GRANT    = 3'd4
    } result_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;

endpackage

// File: rtl/auxreg_tuple_match.sv
module auxreg_tuple_match
    import auxreg_pkg::*;
(
    input  logic [3:0] cp,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);

    logic [4:0] field_ok;

    always_comb begin
        field_ok[0] = (cp  == TUPLE_CP);
        field_ok[1] = (op1 == TUPLE_OP1);
        field_ok[2] = (crn == TUPLE_CRN);
        field_ok[3] = (crm == TUPLE_CRM);
        field_ok[4] = (op2 == TUPLE_OP2);
        hit         = &field_ok;
    end

endmodule

// File: rtl/auxreg_access_resolve.sv
module auxreg_access_resolve
    import auxreg_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] el,
    input  logic       el2_en,
    input  logic       el2_is32,
    input  logic       el3_present,
    input  logic       el3_is32,
    input  logic       ns,
    input  logic       coarse_a64,
    input  logic       coarse_a32,
    input  logic       aux_a64,
    input  logic       aux_a32,
    output result_e    result,
    output slot_e      slot
);

    slot_e lower_slot;
    logic  el2_64_on;
    logic  el2_32_on;

    always_comb begin
        lower_slot = (el3_present && el3_is32) ? SLOT_NSEC : SLOT_UNB;
        el2_64_on  = el2_en && !el2_is32;
        el2_32_on  = el2_en &&  el2_is32;
        result     = RES_MISS;
        slot       = SLOT_UNB;
        if (hit) begin
            unique case (el)
                2'd0: result = RES_UNDEF;
                2'd1: begin
                    slot = lower_slot;
                    if (el2_64_on && coarse_a64)      result = RES_TRAP_A64;
                    else if (el2_32_on && coarse_a32) result = RES_TRAP_A32;
                    else if (el2_64_on && aux_a64)    result = RES_TRAP_A64;
                    else if (el2_32_on && aux_a32)    result = RES_TRAP_A32;
                    else                              result = RES_GRANT;
                end
                2'd2: begin
                    slot   = lower_slot;
                    result = RES_GRANT;
                end
                2'd3: begin
                    slot   = ns ? SLOT_NSEC : SLOT_SEC;
                    result = RES_GRANT;
                end
            endcase
        end
    end

endmodule

// File: rtl/auxreg_bank_store.sv
module auxreg_bank_store #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 3,
    localparam int IW    = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_slot,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [IW-1:0]           rd_slot,
    output logic [DATA_W-1:0]       rd_data,
    output logic [SLOTS*DATA_W-1:0] slot_bus
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_slot == IW'(g))) begin
                val_q <= wr_data;
            end
        end
        assign slot_bus[g*DATA_W +: DATA_W] = val_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_slot == IW'(i)) rd_data = slot_bus[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/banked_auxreg_ctrl.sv
module banked_auxreg_ctrl
    import auxreg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SYND_W     = 6,
    parameter int TRAP_CLASS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_cp,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [1:0]        req_el,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_el2_en,
    input  logic              cfg_el2_is32,
    input  logic              cfg_el3_present,
    input  logic              cfg_el3_is32,
    input  logic              cfg_ns,
    input  logic              cfg_coarse_a64,
    input  logic              cfg_coarse_a32,
    input  logic              cfg_aux_a64,
    input  logic              cfg_aux_a32,
    output logic              rsp_done,
    output logic              rsp_handled,
    output logic              rsp_undef,
    output logic              rsp_trap_sys64,
    output logic              rsp_trap_hyp32,
    output logic [SYND_W-1:0] rsp_syndrome,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [SYND_W-1:0] SYND_VAL = SYND_W'(TRAP_CLASS);

    logic                        tuple_hit;
    result_e                     result;
    slot_e                       slot;
    logic                        store_we;
    logic [DATA_W-1:0]           store_rd;
    logic [NUM_SLOTS*DATA_W-1:0] slot_bus;
    fsm_e                        state_q;
    fsm_e                        state_d;

    auxreg_tuple_match u_match (
        .cp  (req_cp),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (tuple_hit)
    );

    auxreg_access_resolve u_resolve (
        .hit         (tuple_hit),
        .el          (req_el),
        .el2_en      (cfg_el2_en),
        .el2_is32    (cfg_el2_is32),
        .el3_present (cfg_el3_present),
        .el3_is32    (cfg_el3_is32),
        .ns          (cfg_ns),
        .coarse_a64  (cfg_coarse_a64),
        .coarse_a32  (cfg_coarse_a32),
        .aux_a64     (cfg_aux_a64),
        .aux_a32     (cfg_aux_a32),
        .result      (result),
        .slot        (slot)
    );

    assign store_we = req_valid && req_write && (result == RES_GRANT);

    auxreg_bank_store #(
        .DATA_W (DATA_W),
        .SLOTS  (NUM_SLOTS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (store_we),
        .wr_slot  (slot),
        .wr_data  (req_wdata),
        .rd_slot  (slot),
        .rd_data  (store_rd),
        .slot_bus (slot_bus)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: GO (IDLE->RESP), AGAIN (RESP->RESP), REST (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    assign rsp_done = (state_q == ST_RESP);

    // Response registers
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_handled    <= 1'b0;
            rsp_undef      <= 1'b0;
            rsp_trap_sys64 <= 1'b0;
            rsp_trap_hyp32 <= 1'b0;
            rsp_syndrome   <= '0;
            rsp_rdata      <= '0;
        end else begin
            rsp_handled    <= (result != RES_MISS);
            rsp_undef      <= (result == RES_UNDEF);
            rsp_trap_sys64 <= (result == RES_TRAP_A64);
            rsp_trap_hyp32 <= (result == RES_TRAP_A32);
            rsp_syndrome   <= ((result == RES_TRAP_A64) || (result == RES_TRAP_A32))
                              ? SYND_VAL : '0;
            rsp_rdata      <= ((result == RES_GRANT) && !req_write) ? store_rd : '0;
        end
    end

endmodule

// File: rtl/banked_auxreg_chk.sv
module banked_auxreg_chk
    import auxreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SYND_W = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [3:0]                  req_cp,
    input logic [2:0]                  req_op1,
    input logic [3:0]                  req_crn,
    input logic [3:0]                  req_crm,
    input logic [2:0]                  req_op2,
    input logic [1:0]                  req_el,
    input logic [DATA_W-1:0]           req_wdata,
    input logic                        cfg_el2_en,
    input logic                        cfg_el2_is32,
    input logic                        cfg_el3_present,
    input logic                        cfg_el3_is32,
    input logic                        cfg_ns,
    input logic                        cfg_coarse_a64,
    input logic                        cfg_coarse_a32,
    input logic                        cfg_aux_a64,
    input logic                        cfg_aux_a32,
    input logic                        rsp_done,
    input logic                        rsp_handled,
    input logic                        rsp_undef,
    input logic                        rsp_trap_sys64,
    input logic                        rsp_trap_hyp32,
    input logic [SYND_W-1:0]           rsp_syndrome,
    input logic [DATA_W-1:0]           rsp_rdata,
    input logic [NUM_SLOTS*DATA_W-1:0] slot_bus
);

    localparam int IDX_S = int'(SLOT_SEC);
    localparam int IDX_N = int'(SLOT_NSEC);
    localparam int IDX_U = int'(SLOT_UNB);

    logic hit;
    logic on_el1_64;
    logic on_el1_32;
    assign hit = (req_cp == 4'b1111) && (req_op1 == 3'b000) && (req_crn == 4'b0001)
              && (req_crm == 4'b0000) && (req_op2 == 3'b011);
    assign on_el1_64 = req_valid && hit && (req_el == 2'd1) && cfg_el2_en && !cfg_el2_is32;
    assign on_el1_32 = req_valid && hit && (req_el == 2'd1) && cfg_el2_en && cfg_el2_is32;

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (slot_bus == '0));

    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done);

    assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_undef, rsp_trap_sys64, rsp_trap_hyp32}));

    assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (rsp_done && !rsp_handled && !rsp_undef && !rsp_trap_sys64
                                 && !rsp_trap_hyp32 && (rsp_rdata == '0) && $stable(slot_bus)));

    assert_el0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && (req_el == 2'd0)) |=> (rsp_undef && $stable(slot_bus)));

    assert_coarse64_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_el1_64 && cfg_coarse_a64) |=> rsp_trap_sys64);

    assert_coarse32_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_el1_32 && cfg_coarse_a32) |=> rsp_trap_hyp32);

    assert_aux64_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_el1_64 && cfg_aux_a64) |=> rsp_trap_sys64);

    assert_aux32_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_el1_32 && cfg_aux_a32) |=> rsp_trap_hyp32);

    assert_syndrome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap_sys64 || rsp_trap_hyp32) |-> (rsp_syndrome == SYND_W'(3)));

    assert_syndrome_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_trap_sys64 || rsp_trap_hyp32) |-> (rsp_syndrome == '0));

    assert_el2_unb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_write && (req_el == 2'd2) && !(cfg_el3_present && cfg_el3_is32))
        |=> (slot_bus[IDX_U*DATA_W +: DATA_W] == $past(req_wdata)));

    assert_el3_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_write && (req_el == 2'd3) && !cfg_ns)
        |=> (slot_bus[IDX_S*DATA_W +: DATA_W] == $past(req_wdata)));

    assert_el3_nsec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_write && (req_el == 2'd3) && cfg_ns)
        |=> (slot_bus[IDX_N*DATA_W +: DATA_W] == $past(req_wdata)));

    assert_fail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_undef || rsp_trap_sys64 || rsp_trap_hyp32) |-> (rsp_rdata == '0));

    assert_fail_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_undef || rsp_trap_sys64 || rsp_trap_hyp32) |-> $stable(slot_bus));

endmodule

bind banked_auxreg_ctrl banked_auxreg_chk #(
    .DATA_W (DATA_W),
    .SYND_W (SYND_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_cp          (req_cp),
    .req_op1         (req_op1),
    .req_crn         (req_crn),
    .req_crm         (req_crm),
    .req_op2         (req_op2),
    .req_el          (req_el),
    .req_wdata       (req_wdata),
    .cfg_el2_en      (cfg_el2_en),
    .cfg_el2_is32    (cfg_el2_is32),
    .cfg_el3_present (cfg_el3_present),
    .cfg_el3_is32    (cfg_el3_is32),
    .cfg_ns          (cfg_ns),
    .cfg_coarse_a64  (cfg_coarse_a64),
    .cfg_coarse_a32  (cfg_coarse_a32),
    .cfg_aux_a64     (cfg_aux_a64),
    .cfg_aux_a32     (cfg_aux_a32),
    .rsp_done        (rsp_done),
    .rsp_handled     (rsp_handled),
    .rsp_undef       (rsp_undef),
    .rsp_trap_sys64  (rsp_trap_sys64),
    .rsp_trap_hyp32  (rsp_trap_hyp32),
    .rsp_syndrome    (rsp_syndrome),
    .rsp_rdata       (rsp_rdata),
    .slot_bus        (slot_bus)
);

// File: tb/banked_auxreg_ctrl_tb.sv
`timescale 1ns/1ps
module banked_auxreg_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [3:0]  req_cp, req_crn, req_crm;
    logic [2:0]  req_op1, req_op2;
    logic [1:0]  req_el;
    logic [31:0] req_wdata;
    logic        cfg_el2_en, cfg_el2_is32, cfg_el3_present, cfg_el3_is32, cfg_ns;
    logic        cfg_coarse_a64, cfg_coarse_a32, cfg_aux_a64, cfg_aux_a32;
    logic        rsp_done, rsp_handled, rsp_undef, rsp_trap_sys64, rsp_trap_hyp32;
    logic [5:0]  rsp_syndrome;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    banked_auxreg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cp(req_cp), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_el(req_el), .req_wdata(req_wdata),
        .cfg_el2_en(cfg_el2_en), .cfg_el2_is32(cfg_el2_is32),
        .cfg_el3_present(cfg_el3_present), .cfg_el3_is32(cfg_el3_is32), .cfg_ns(cfg_ns),
        .cfg_coarse_a64(cfg_coarse_a64), .cfg_coarse_a32(cfg_coarse_a32),
        .cfg_aux_a64(cfg_aux_a64), .cfg_aux_a32(cfg_aux_a32),
        .rsp_done(rsp_done), .rsp_handled(rsp_handled), .rsp_undef(rsp_undef),
        .rsp_trap_sys64(rsp_trap_sys64), .rsp_trap_hyp32(rsp_trap_hyp32),
        .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata)
    );

    // cfg order: {el2_en, el2_is32, el3_present, el3_is32, ns, coarse64, coarse32, aux64, aux32}
    // kind: 0 miss, 1 undef, 2 trap to 64-bit EL2, 3 trap to 32-bit EL2, 4 grant
    typedef struct packed {
        logic        wr;
        logic [1:0]  el;
        logic [8:0]  cfg;
        logic [31:0] wd;
        logic [2:0]  kind;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd3, 9'b0000_0_0000, 32'hA1A1A1A1, 3'd4, 32'h0},
        '{1'b1, 2'd3, 9'b0000_1_0000, 32'hB2B2B2B2, 3'd4, 32'h0},
        '{1'b1, 2'd2, 9'b0011_0_0000, 32'hC3C3C3C3, 3'd4, 32'h0},
        '{1'b1, 2'd2, 9'b0000_0_0000, 32'hD4D4D4D4, 3'd4, 32'h0},
        '{1'b0, 2'd3, 9'b0000_0_0000, 32'h0,        3'd4, 32'hA1A1A1A1},
        '{1'b0, 2'd3, 9'b0000_1_0000, 32'h0,        3'd4, 32'hC3C3C3C3},
        '{1'b0, 2'd1, 9'b0011_0_0000, 32'h0,        3'd4, 32'hC3C3C3C3},
        '{1'b0, 2'd1, 9'b0010_0_0000, 32'h0,        3'd4, 32'hD4D4D4D4},
        '{1'b1, 2'd0, 9'b0011_1_1111, 32'hFFFFFFFF, 3'd1, 32'h0},
        '{1'b0, 2'd0, 9'b0000_0_0000, 32'h0,        3'd1, 32'h0},
        '{1'b1, 2'd1, 9'b1000_0_1000, 32'h55555555, 3'd2, 32'h0},
        '{1'b0, 2'd1, 9'b1100_0_0100, 32'h0,        3'd3, 32'h0},
        '{1'b0, 2'd1, 9'b1000_0_0010, 32'h0,        3'd2, 32'h0},
        '{1'b1, 2'd1, 9'b1100_0_0001, 32'h66666666, 3'd3, 32'h0},
        '{1'b0, 2'd1, 9'b1000_0_0101, 32'h0,        3'd4, 32'hD4D4D4D4},
        '{1'b0, 2'd1, 9'b0000_0_1010, 32'h0,        3'd4, 32'hD4D4D4D4},
        '{1'b1, 2'd1, 9'b1111_0_1010, 32'h77777777, 3'd4, 32'h0},
        '{1'b0, 2'd2, 9'b1111_0_0101, 32'h0,        3'd4, 32'h77777777},
        '{1'b0, 2'd3, 9'b0000_0_0000, 32'h0,        3'd4, 32'hA1A1A1A1},
        '{1'b0, 2'd1, 9'b1000_0_1111, 32'h0,        3'd2, 32'h0},
        '{1'b0, 2'd1, 9'b1100_0_1111, 32'h0,        3'd3, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_tuple_ok();
        req_cp = 4'b1111; req_op1 = 3'b000; req_crn = 4'b0001; req_crm = 4'b0000; req_op2 = 3'b011;
    endtask

    // Present one request for one cycle; outputs are sampled at the return.
    task automatic issue(input logic wr, input logic [1:0] el, input logic [8:0] cfg,
                         input logic [31:0] wd);
        @(negedge clk);
        req_write = wr; req_el = el; req_wdata = wd;
        {cfg_el2_en, cfg_el2_is32, cfg_el3_present, cfg_el3_is32, cfg_ns,
         cfg_coarse_a64, cfg_coarse_a32, cfg_aux_a64, cfg_aux_a32} = cfg;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        set_tuple_ok();
    endtask

    function automatic logic [31:0] flags();
        return {26'h0, rsp_done, rsp_handled, rsp_undef, rsp_trap_sys64, rsp_trap_hyp32, 1'b0};
    endfunction

    function automatic logic [31:0] exp_flags(input logic [2:0] kind);
        return {26'h0, 1'b1, kind != 3'd0, kind == 3'd1, kind == 3'd2, kind == 3'd3, 1'b0};
    endfunction

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_el = 2'd0; req_wdata = '0;
        {cfg_el2_en, cfg_el2_is32, cfg_el3_present, cfg_el3_is32, cfg_ns,
         cfg_coarse_a64, cfg_coarse_a32, cfg_aux_a64, cfg_aux_a32} = '0;
        set_tuple_ok();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state of outputs and of every copy
        check("R7 outputs after reset", flags(), 32'h0);
        check("R7 syndrome after reset", {26'h0, rsp_syndrome}, 32'h0);
        issue(1'b0, 2'd3, 9'b0000_0_0000, '0);
        check("R7 secure copy reset", rsp_rdata, 32'h0);
        issue(1'b0, 2'd3, 9'b0000_1_0000, '0);
        check("R7 non-secure copy reset", rsp_rdata, 32'h0);
        issue(1'b0, 2'd2, 9'b0000_0_0000, '0);
        check("R7 unbanked copy reset", rsp_rdata, 32'h0);

        // R9: done drops when no request follows
        @(negedge clk);
        check("R9 done drops after one cycle", {31'h0, rsp_done}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            unique case (VECS[i].kind)
                3'd1:    tag = "R2";
                3'd2:    tag = "R3 R4 trap64";
                3'd3:    tag = "R3 R4 trap32";
                default: tag = (VECS[i].el == 2'd3) ? "R6" : "R5";
            endcase
            issue(VECS[i].wr, VECS[i].el, VECS[i].cfg, VECS[i].wd);
            check($sformatf("%s vec%0d flags", tag, i), flags(), exp_flags(VECS[i].kind));
            check($sformatf("R4 vec%0d syndrome", i), {26'h0, rsp_syndrome},
                  ((VECS[i].kind == 3'd2) || (VECS[i].kind == 3'd3)) ? 32'h3 : 32'h0);
            check($sformatf("%s R8 vec%0d rdata", tag, i), rsp_rdata, VECS[i].rd);
        end

        // R8: trapped/undefined writes left the non-secure and unbanked copies intact
        issue(1'b0, 2'd3, 9'b0000_1_0000, '0);
        check("R8 non-secure copy kept", rsp_rdata, 32'h77777777);
        issue(1'b0, 2'd2, 9'b0000_0_0000, '0);
        check("R8 unbanked copy kept", rsp_rdata, 32'hD4D4D4D4);

        // R1: each tuple field mismatched alone, write to secure copy from EL3
        for (int f = 0; f < 6; f++) begin
            @(negedge clk);
            set_tuple_ok();
            unique case (f)
                0: req_cp  = 4'b1110;
                1: req_op1 = 3'b001;
                2: req_crn = 4'b0000;
                3: req_crm = 4'b0001;
                4: req_op2 = 3'b010;
                default: req_op2 = 3'b111;
            endcase
            req_write = 1'b1; req_el = (f == 5) ? 2'd0 : 2'd3; req_wdata = 32'hDEADBEEF;
            {cfg_el2_en, cfg_el2_is32, cfg_el3_present, cfg_el3_is32, cfg_ns,
             cfg_coarse_a64, cfg_coarse_a32, cfg_aux_a64, cfg_aux_a32} = '0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            set_tuple_ok();
            check($sformatf("R1 miss field%0d flags", f), flags(), exp_flags(3'd0));
            check($sformatf("R1 miss field%0d rdata", f), rsp_rdata, 32'h0);
            issue(1'b0, 2'd3, 9'b0000_0_0000, '0);
            check($sformatf("R1 miss field%0d no write", f), rsp_rdata, 32'hA1A1A1A1);
        end

        // R9: back-to-back requests keep done high, read sees prior write
        @(negedge clk);
        req_write = 1'b1; req_el = 2'd3; req_wdata = 32'h12345678; cfg_ns = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        check("R9 done first of pair", {31'h0, rsp_done}, 32'h1);
        req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 done second of pair", {31'h0, rsp_done}, 32'h1);
        check("R6 read after back-to-back write", rsp_rdata, 32'h12345678);
        @(negedge clk);
        check("R9 done low after pair", {31'h0, rsp_done}, 32'h0);

        finish_run();
    end

endmodule